// File: doc/BRIEF.md
# Endpoint Discovery State Controller

This block keeps the discovery state of a management endpoint that talks over PCIe vendor-defined messages. It holds a discovered flag, the endpoint ID (EID) it has been given, the requester ID and EID of the bus owner that gave it, and the bus number from the latest Type 0 configuration write. Its inputs are events that a message decoder elsewhere has already decoded: a discovery-reset broadcast, a discovery probe, an EID assignment, configuration writes, EID-loss indications, and a non-responsive level that is timed with a tick.

It produces two one-cycle requests. The first asks the message builder to announce the endpoint to the bus owner after the bus number changes. The second grants permission to answer a discovery probe. It also supplies the routing code, destination EID and source EID that the builder places in either message. The reclaim interval, which is how long the endpoint may stay unable to answer before it counts as undiscovered, is a parameter counted in ticks.

Top module: `ep_disc_state`

## Requirements
- R1: An EID assignment event sets the discovered flag and `eid_valid`, and stores the assigned EID, the sender's requester ID and the sender's EID. All of these are visible one cycle after the event.
- R2: A discovery-reset broadcast event clears the discovered flag on the next cycle.
- R3: A configuration write that changes the bus number clears the flag. An EID-loss event also clears the flag, clears `eid_valid`, and makes the message source EID 0x00.
- R4: `reply_ok` pulses for one cycle, on the cycle after a discovery probe, only if the flag was clear when the probe arrived. A probe that arrives while the flag is set produces no pulse.
- R5: `notify_req` pulses for one cycle, on the cycle after a configuration write, when no bus number has been stored yet or the written number differs from the stored one. A write of the same number produces no pulse. `bus_num` takes the written value.
- R6: The announcement header uses routing code 3'b000 (toward the root complex) and destination EID 0x00. Its source EID is 0x00 while no EID is assigned and the assigned EID otherwise.
- R7: The probe-reply header uses routing code 3'b000 and the same source EID rule as R6.
- R8: While `stalled` is high, each cycle with `tick` high advances a counter. The `RECLAIM_TICKS`-th such cycle clears the flag. Lowering `stalled` restarts the count, and cycles without `tick` do not advance it.
- R9: When an EID assignment arrives in the same cycle as any clearing event, the flag ends up clear.
- R10: After reset the flag, `eid_valid`, the stored EID, the owner fields and `bus_num` are all zero, no requests are pending, and the next configuration write always counts as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_prep | input | 1 | Discovery-reset broadcast received |
| ev_probe | input | 1 | Discovery probe received |
| ev_assign | input | 1 | EID assignment received |
| assign_eid | input | 8 | EID carried by the assignment |
| assign_rid | input | 16 | Requester ID of the assignment's sender |
| assign_src | input | 8 | Source EID of the assignment's sender |
| cfg_wr | input | 1 | Type 0 configuration write seen |
| cfg_bus | input | 8 | Bus number captured from that write |
| eid_lost | input | 1 | The endpoint lost its EID |
| tick | input | 1 | Timebase enable for the reclaim count |
| stalled | input | 1 | The endpoint cannot answer control requests |
| discovered | output | 1 | Discovered flag |
| eid_valid | output | 1 | An EID is assigned |
| my_eid | output | 8 | Assigned EID |
| owner_rid | output | 16 | Bus owner requester ID |
| owner_eid | output | 8 | Bus owner EID |
| bus_num | output | 8 | Stored bus number |
| notify_req | output | 1 | Request to send an announcement |
| reply_ok | output | 1 | Permission to answer the probe |
| msg_route | output | 3 | Routing code for both messages |
| msg_dst_eid | output | 8 | Destination EID for the announcement |
| msg_src_eid | output | 8 | Source EID for both messages |

## Verification
The hardest state to reach from the ports is the edge of the reclaim window. There the flag must survive a stall that ends one tick short of the limit, and it must also survive a long stall during which no tick arrives. With the interval shortened to four ticks, the stimulus raises `stalled` for three ticked cycles and drops it. It then holds `stalled` with `tick` low. Only after that does it allow a full run of four ticked cycles, and it checks that the flag falls on that run and on no earlier cycle. A second case places a reset between two writes of the same bus number, to show that the first write after reset still raises an announcement.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int EID_W = 8;
  localparam int RID_W = 16;
  localparam int BUS_W = 8;
  localparam logic [2:0] ROUTE_TO_RC = 3'b000;
  localparam logic [EID_W-1:0] NULL_EID = '0;
endpackage

// File: rtl/disc_flag_reg.sv
module disc_flag_reg
  import disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ev,
  input  logic             clr_ev,
  input  logic             lose_ev,
  input  logic [EID_W-1:0] eid_in,
  input  logic [RID_W-1:0] rid_in,
  input  logic [EID_W-1:0] src_in,
  output logic             flag_q,
  output logic             valid_q,
  output logic [EID_W-1:0] eid_q,
  output logic [RID_W-1:0] rid_q,
  output logic [EID_W-1:0] src_q
);
  logic flag_d, valid_d;

  always_comb begin
    flag_d  = flag_q;
    valid_d = valid_q;
    if (clr_ev)      flag_d = 1'b0;
    else if (set_ev) flag_d = 1'b1;
    if (lose_ev)     valid_d = 1'b0;
    else if (set_ev) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eid_q <= '0;
      rid_q <= '0;
      src_q <= '0;
    end else if (set_ev) begin
      eid_q <= eid_in;
      rid_q <= rid_in;
      src_q <= src_in;
    end
  end
endmodule

// File: rtl/disc_bus_track.sv
module disc_bus_track
  import disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] bus_in,
  output logic             changed,
  output logic             notify_q,
  output logic [BUS_W-1:0] bus_q
);
  logic known_q;

  always_comb begin
    changed = wr && (!known_q || (bus_in != bus_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q  <= 1'b0;
      bus_q    <= '0;
      notify_q <= 1'b0;
    end else begin
      notify_q <= changed;
      if (wr) begin
        known_q <= 1'b1;
        bus_q   <= bus_in;
      end
    end
  end
endmodule

// File: rtl/disc_reclaim.sv
module disc_reclaim #(
  parameter int unsigned RECLAIM_TICKS = 32'd50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stalled,
  output logic expire
);
  localparam int CNT_W = $clog2(RECLAIM_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RECLAIM_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = stalled && tick && (cnt_q == LIMIT - 1'b1);
    cnt_d  = cnt_q;
    if (!stalled)                   cnt_d = '0;
    else if (tick && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ep_disc_state.sv
module ep_disc_state
  import disc_pkg::*;
#(
  parameter int unsigned RECLAIM_TICKS = 32'd50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_prep,
  input  logic             ev_probe,
  input  logic             ev_assign,
  input  logic [EID_W-1:0] assign_eid,
  input  logic [RID_W-1:0] assign_rid,
  input  logic [EID_W-1:0] assign_src,
  input  logic             cfg_wr,
  input  logic [BUS_W-1:0] cfg_bus,
  input  logic             eid_lost,
  input  logic             tick,
  input  logic             stalled,
  output logic             discovered,
  output logic             eid_valid,
  output logic [EID_W-1:0] my_eid,
  output logic [RID_W-1:0] owner_rid,
  output logic [EID_W-1:0] owner_eid,
  output logic [BUS_W-1:0] bus_num,
  output logic             notify_req,
  output logic             reply_ok,
  output logic [2:0]       msg_route,
  output logic [EID_W-1:0] msg_dst_eid,
  output logic [EID_W-1:0] msg_src_eid
);
  logic bus_changed, reclaim_hit, clr_any, reply_d;

  disc_bus_track u_bus (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .bus_in(cfg_bus),
    .changed(bus_changed), .notify_q(notify_req), .bus_q(bus_num)
  );

  disc_reclaim #(.RECLAIM_TICKS(RECLAIM_TICKS)) u_rcl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stalled(stalled),
    .expire(reclaim_hit)
  );

  always_comb begin
    clr_any = ev_prep || bus_changed || eid_lost || reclaim_hit;
    reply_d = ev_probe && !discovered;
  end

  disc_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_assign), .clr_ev(clr_any),
    .lose_ev(eid_lost), .eid_in(assign_eid), .rid_in(assign_rid),
    .src_in(assign_src), .flag_q(discovered), .valid_q(eid_valid),
    .eid_q(my_eid), .rid_q(owner_rid), .src_q(owner_eid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reply_ok <= 1'b0;
    else        reply_ok <= reply_d;
  end

  always_comb begin
    msg_route   = ROUTE_TO_RC;
    msg_dst_eid = NULL_EID;
    msg_src_eid = eid_valid ? my_eid : NULL_EID;
  end
endmodule

// File: rtl/ep_disc_state_chk.sv
module ep_disc_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_prep,
  input logic       ev_probe,
  input logic       ev_assign,
  input logic       cfg_wr,
  input logic       eid_lost,
  input logic       stalled,
  input logic       discovered,
  input logic       eid_valid,
  input logic       notify_req,
  input logic       reply_ok,
  input logic [7:0] msg_src_eid
);
  a_r1_assign_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_assign && !ev_prep && !eid_lost && !cfg_wr && !stalled) |=> (discovered && eid_valid));

  a_r2_prep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prep |=> !discovered);

  a_r3_loss_unassigns: assert property (@(posedge clk) disable iff (!rst_n)
    eid_lost |=> (!eid_valid && !discovered));

  a_r4_probe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe && discovered) |=> !reply_ok);

  a_r4_reply_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |-> $past(ev_probe));

  a_r5_notify_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |-> $past(cfg_wr));

  a_r6_null_src: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_req && !eid_valid) |-> (msg_src_eid == 8'h00));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_assign && ev_prep) |=> !discovered);
endmodule

bind ep_disc_state ep_disc_state_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ev_prep(ev_prep), .ev_probe(ev_probe),
  .ev_assign(ev_assign), .cfg_wr(cfg_wr), .eid_lost(eid_lost),
  .stalled(stalled), .discovered(discovered), .eid_valid(eid_valid),
  .notify_req(notify_req), .reply_ok(reply_ok), .msg_src_eid(msg_src_eid)
);

// File: tb/ep_disc_state_tb_top.sv
module ep_disc_state_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_prep = 0, ev_probe = 0, ev_assign = 0, cfg_wr = 0, eid_lost = 0;
  logic tick = 1'b1, stalled = 1'b0;
  logic [7:0] assign_eid = 0, assign_src = 0, cfg_bus = 0;
  logic [15:0] assign_rid = 0;
  logic discovered, eid_valid, notify_req, reply_ok;
  logic [7:0] my_eid, owner_eid, bus_num, msg_dst_eid, msg_src_eid;
  logic [15:0] owner_rid;
  logic [2:0] msg_route;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [8:0] expq[$];  // {kind(0=notify,1=reply), src eid}

  always #10 clk = ~clk;

  ep_disc_state #(.RECLAIM_TICKS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_prep(ev_prep), .ev_probe(ev_probe),
    .ev_assign(ev_assign), .assign_eid(assign_eid), .assign_rid(assign_rid),
    .assign_src(assign_src), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus),
    .eid_lost(eid_lost), .tick(tick), .stalled(stalled),
    .discovered(discovered), .eid_valid(eid_valid), .my_eid(my_eid),
    .owner_rid(owner_rid), .owner_eid(owner_eid), .bus_num(bus_num),
    .notify_req(notify_req), .reply_ok(reply_ok), .msg_route(msg_route),
    .msg_dst_eid(msg_dst_eid), .msg_src_eid(msg_src_eid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected announcements and replies as they appear.
  task automatic take(logic kind, string req);
    logic [8:0] it;
    total++;
    if (expq.size() == 0) begin
      bad++;
      $display("FAIL %s actual=unexpected pulse kind %0d expected=none", req, kind);
    end else begin
      it = expq.pop_front();
      if (it[8] !== kind || it[7:0] !== msg_src_eid || msg_route !== 3'b000 ||
          (kind == 1'b0 && msg_dst_eid !== 8'h00)) begin
        bad++;
        $display("FAIL %s actual=kind%0d src=%0h route=%0b dst=%0h expected=kind%0d src=%0h route=0 dst=0",
                 req, kind, msg_src_eid, msg_route, msg_dst_eid, it[8], it[7:0]);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (notify_req) take(1'b0, "R5/R6 notify");
      if (reply_ok)   take(1'b1, "R4/R7 reply");
    end
  end

  task automatic do_cfg(logic [7:0] b, bit exp_n, logic [7:0] src);
    @(negedge clk);
    cfg_wr = 1; cfg_bus = b;
    if (exp_n) expq.push_back({1'b0, src});
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic do_probe(bit exp_r, logic [7:0] src);
    @(negedge clk);
    ev_probe = 1;
    if (exp_r) expq.push_back({1'b1, src});
    @(negedge clk);
    ev_probe = 0;
  endtask

  task automatic do_assign(logic [7:0] e, logic [15:0] r, logic [7:0] s);
    @(negedge clk);
    ev_assign = 1; assign_eid = e; assign_rid = r; assign_src = s;
    @(negedge clk);
    ev_assign = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R10 reset state
    chk("R10 flag", discovered, 0);
    chk("R10 eid_valid", eid_valid, 0);
    chk("R10 bus", bus_num, 0);
    chk("R10 owner_rid", owner_rid, 0);
    @(negedge clk); rst_n = 1;
    idle(1);
    chk("R10 no notify", notify_req, 0);
    // R4 R7 probe while undiscovered, null source
    do_probe(1, 8'h00);
    // R5 R6 first write triggers announcement with null source
    do_cfg(8'h05, 1, 8'h00);
    chk("R5 bus stored", bus_num, 8'h05);
    do_cfg(8'h05, 0, 8'h00);   // R5 same bus: no announcement
    // R1 assignment
    do_assign(8'h21, 16'h0100, 8'h08);
    chk("R1 flag", discovered, 1);
    chk("R1 eid", my_eid, 8'h21);
    chk("R1 owner rid", owner_rid, 16'h0100);
    chk("R1 owner eid", owner_eid, 8'h08);
    chk("R1 valid", eid_valid, 1);
    // R4 probe ignored while discovered
    do_probe(0, 8'h00);
    idle(2);
    chk("R4 no reply", reply_ok, 0);
    // R3 R6 bus change clears flag, announcement with assigned EID
    do_cfg(8'h06, 1, 8'h21);
    chk("R3 bus change clears", discovered, 0);
    do_probe(1, 8'h21);        // R7 source is assigned EID
    // R2 broadcast reset
    do_assign(8'h22, 16'h0200, 8'h09);
    chk("R1 flag again", discovered, 1);
    @(negedge clk); ev_prep = 1; @(negedge clk); ev_prep = 0;
    chk("R2 prep clears", discovered, 0);
    // R3 EID loss
    do_assign(8'h23, 16'h0200, 8'h09);
    @(negedge clk); eid_lost = 1; @(negedge clk); eid_lost = 0;
    chk("R3 loss flag", discovered, 0);
    chk("R3 loss valid", eid_valid, 0);
    chk("R3 loss src", msg_src_eid, 8'h00);
    do_probe(1, 8'h00);
    // R8 reclaim window
    do_assign(8'h24, 16'h0300, 8'h0A);
    @(negedge clk); stalled = 1; idle(3); stalled = 0;
    chk("R8 short stall keeps", discovered, 1);
    @(negedge clk); stalled = 1; tick = 0; idle(10); tick = 1; idle(3);
    chk("R8 ticks only", discovered, 1);
    stalled = 0; @(negedge clk); stalled = 1; idle(3);
    chk("R8 before limit", discovered, 1);
    idle(1); stalled = 0;
    chk("R8 expired", discovered, 0);
    // R9 same-cycle assign and clear
    @(negedge clk);
    ev_assign = 1; ev_prep = 1; assign_eid = 8'h30;
    @(negedge clk); ev_assign = 0; ev_prep = 0;
    chk("R9 clear wins", discovered, 0);
    chk("R9 eid still stored", my_eid, 8'h30);
    // R10 reset forgets bus: same bus number announces again
    @(negedge clk); rst_n = 0; @(negedge clk);
    chk("R10 reset eid", my_eid, 0);
    rst_n = 1;
    do_cfg(8'h06, 1, 8'h00);
    idle(3);
    chk("R5 queue drained", expq.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule